// File: doc/BRIEF.md
# Masked-Write Control Register Bank

This block holds a small set of 32-bit control words behind a single-cycle bus with a valid strobe and a write flag. Each write carries its own bit enables: the upper half-word of the write data selects which bits of the lower half-word are stored. Software can therefore change one field of a control word without reading it first. Bits that are not enabled in a write keep their value.

The stored words drive lane enables, forced receive and forced stop controls, turnaround disables and turn requests, two clock polarity selects, and the pins of a byte-wide test port. A read-only status word returns the test port's 8-bit readback input. Reads answer one cycle after the strobe with a valid flag. Unmapped addresses do nothing on a write and read as zero.

Top module: `hwm_ctrl_bank`

## Requirements
- R1: After reset every control output is 0, `rd_valid` is 0, and every control word reads back as 0.
- R2: A write changes data bit n (0..15) of the addressed word only when write-data bit n+16 is 1. A write with all enables clear changes nothing.
- R3: A write is sampled on the rising clock edge where `bus_valid` and `bus_write` are high. The new value is on the outputs right after that edge, with no wait state.
- R4: The lane word is at byte offset 0x00. Its fields are `lane_en` at [3:0], `force_rx` at [7:4], `force_stop` at [11:8] and `turn_dis` at [15:12].
- R5: The aux word is at 0x04. It holds `turn_req` at [3:0] and `clk_inv` bits 0 and 1 at bits 10 and 11. Its other bits are not stored and read as 0.
- R6: The test-port word is at 0x08. It holds `tp_din` at [7:0], `tp_en` at bit 8, `tp_clk` at bit 9 and `tp_clr` at bit 10. Bits [15:11] are not stored and read as 0.
- R7: The status word is at 0x0C. It returns `tp_dout` in [7:0] and 0 elsewhere, and writes to it change nothing.
- R8: A read, meaning `bus_valid` high with `bus_write` low, raises `rd_valid` for exactly the next cycle. `rd_data` then carries 0 in [31:16] and the stored word in [15:0]. Reads change no control output.
- R9: Word offsets 0x10 and above are unmapped. Writes there change nothing, and reads there return 0.
- R10: Address bits [1:0] are ignored, so 0x05 selects the aux word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Transfer strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | [31:16] bit enables, [15:0] data |
| rd_valid | output | 1 | Read data valid, one cycle after a read |
| rd_data | output | 32 | Read data |
| lane_en | output | 4 | Lane enables |
| force_rx | output | 4 | Forced receive mode per lane |
| force_stop | output | 4 | Forced stop state per lane |
| turn_dis | output | 4 | Turnaround disable per lane |
| turn_req | output | 4 | Turn request per lane |
| clk_inv | output | 2 | Clock polarity selects |
| tp_din | output | 8 | Test port data-in |
| tp_en | output | 1 | Test port enable |
| tp_clk | output | 1 | Test port clock |
| tp_clr | output | 1 | Test port clear |
| tp_dout | input | 8 | Test port readback |

## Verification
The hardest case to reach from the ports is a partial-enable write: one field of a word must change while the bits beside it, set earlier to the opposite value, stay put. The stimulus first fills a word with a pattern that has both ones and zeros. It then writes all-ones data with enables covering a single field, and after that writes with all enables clear. A shadow model tracks every stored bit and checks the output pins after each write. Reads of every word, including bits that are not stored, go through a queue-based scoreboard. Reads are also issued back to back so the one-cycle response can be seen without gaps.

// File: rtl/hwm_pkg.sv
package hwm_pkg;
  localparam int DATA_W    = 32;
  localparam int HALF_W    = DATA_W / 2;
  localparam int LANES     = 4;
  localparam int NUM_CTRL  = 3;
  localparam int NUM_WORDS = NUM_CTRL + 1;
  localparam int TP_W      = 8;

  typedef enum int {
    W_LANE = 0,
    W_AUX  = 1,
    W_TEST = 2
  } word_id_e;

  // field positions inside the lane word
  localparam int LN_EN_LSB   = 0;
  localparam int LN_FRX_LSB  = 4;
  localparam int LN_FSTP_LSB = 8;
  localparam int LN_TDIS_LSB = 12;
  // aux word
  localparam int AX_TREQ_LSB = 0;
  localparam int AX_INV_LSB  = 10;
  // test-port word
  localparam int TP_DIN_LSB  = 0;
  localparam int TP_EN_BIT   = 8;
  localparam int TP_CLK_BIT  = 9;
  localparam int TP_CLR_BIT  = 10;

  // storage mask per control word: bits that exist as flops
  function automatic logic [HALF_W-1:0] word_impl_mask(input int id);
    logic [HALF_W-1:0] m;
    m = '0;
    case (id)
      W_LANE: m = '1;
      W_AUX: begin
        m[AX_TREQ_LSB +: LANES] = '1;
        m[AX_INV_LSB +: 2]      = 2'b11;
      end
      W_TEST: begin
        m[TP_DIN_LSB +: TP_W] = '1;
        m[TP_EN_BIT]  = 1'b1;
        m[TP_CLK_BIT] = 1'b1;
        m[TP_CLR_BIT] = 1'b1;
      end
      default: m = '0;
    endcase
    return m;
  endfunction

  // per-bit enabled merge of new data into the old word
  function automatic logic [HALF_W-1:0] masked_merge(
    input logic [HALF_W-1:0] old_v,
    input logic [HALF_W-1:0] new_v,
    input logic [HALF_W-1:0] en,
    input logic [HALF_W-1:0] impl
  );
    return ((old_v & ~en) | (new_v & en)) & impl;
  endfunction
endpackage

// File: rtl/hwm_decode.sv
module hwm_decode
  import hwm_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0]   addr,
  output logic [NUM_CTRL-1:0] ctrl_sel,
  output logic                status_sel,
  output logic                mapped
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] word_idx;
  logic [1:0]       unused_byte_lane;

  assign word_idx         = addr[ADDR_W-1:2];
  assign unused_byte_lane = addr[1:0];

  for (genvar k = 0; k < NUM_CTRL; k++) begin : g_sel
    assign ctrl_sel[k] = (word_idx == IDX_W'(k));
  end

  assign status_sel = (word_idx == IDX_W'(NUM_CTRL));
  assign mapped     = (word_idx < IDX_W'(NUM_WORDS));
endmodule

// File: rtl/hwm_mreg.sv
module hwm_mreg
  import hwm_pkg::*;
#(
  parameter logic [HALF_W-1:0] IMPL = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [HALF_W-1:0] wr_val,
  input  logic [HALF_W-1:0] wr_en,
  output logic [HALF_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (we) begin
      q <= masked_merge(q, wr_val, wr_en, IMPL);
    end
  end
endmodule

// File: rtl/hwm_rdmux.sv
module hwm_rdmux
  import hwm_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           rd_req,
  input  logic [NUM_CTRL-1:0]            ctrl_sel,
  input  logic                           status_sel,
  input  logic [NUM_CTRL-1:0][HALF_W-1:0] words,
  input  logic [TP_W-1:0]                status_in,
  output logic                           rd_valid,
  output logic [DATA_W-1:0]              rd_data
);
  logic [DATA_W-1:0] rd_next;

  always_comb begin
    rd_next = '0;
    for (int k = 0; k < NUM_CTRL; k++) begin
      if (ctrl_sel[k]) rd_next = {{HALF_W{1'b0}}, words[k]};
    end
    if (status_sel) rd_next = {{(DATA_W-TP_W){1'b0}}, status_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) rd_data <= rd_next;
    end
  end
endmodule

// File: rtl/hwm_ctrl_bank.sv
module hwm_ctrl_bank
  import hwm_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic              rd_valid,
  output logic [31:0]       rd_data,
  output logic [3:0]        lane_en,
  output logic [3:0]        force_rx,
  output logic [3:0]        force_stop,
  output logic [3:0]        turn_dis,
  output logic [3:0]        turn_req,
  output logic [1:0]        clk_inv,
  output logic [7:0]        tp_din,
  output logic              tp_en,
  output logic              tp_clk,
  output logic              tp_clr,
  input  logic [7:0]        tp_dout
);
  logic [NUM_CTRL-1:0]             ctrl_sel;
  logic                            status_sel;
  logic                            addr_mapped;
  logic                            wr_req;
  logic                            rd_req;
  logic [NUM_CTRL-1:0]             wr_hit;
  logic [HALF_W-1:0]               wr_val;
  logic [HALF_W-1:0]               wr_en;
  logic [NUM_CTRL-1:0][HALF_W-1:0] words;

  assign wr_req = bus_valid && bus_write;
  assign rd_req = bus_valid && !bus_write;
  assign wr_val = bus_wdata[HALF_W-1:0];
  assign wr_en  = bus_wdata[DATA_W-1:HALF_W];
  assign wr_hit = ctrl_sel & {NUM_CTRL{wr_req}};

  hwm_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr       (bus_addr),
    .ctrl_sel   (ctrl_sel),
    .status_sel (status_sel),
    .mapped     (addr_mapped)
  );

  for (genvar k = 0; k < NUM_CTRL; k++) begin : g_word
    hwm_mreg #(.IMPL(word_impl_mask(k))) u_reg (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (wr_hit[k]),
      .wr_val (wr_val),
      .wr_en  (wr_en),
      .q      (words[k])
    );
  end

  hwm_rdmux u_rd (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_req     (rd_req),
    .ctrl_sel   (ctrl_sel),
    .status_sel (status_sel),
    .words      (words),
    .status_in  (tp_dout),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data)
  );

  assign lane_en    = words[W_LANE][LN_EN_LSB   +: LANES];
  assign force_rx   = words[W_LANE][LN_FRX_LSB  +: LANES];
  assign force_stop = words[W_LANE][LN_FSTP_LSB +: LANES];
  assign turn_dis   = words[W_LANE][LN_TDIS_LSB +: LANES];
  assign turn_req   = words[W_AUX][AX_TREQ_LSB  +: LANES];
  assign clk_inv    = words[W_AUX][AX_INV_LSB   +: 2];
  assign tp_din     = words[W_TEST][TP_DIN_LSB  +: TP_W];
  assign tp_en      = words[W_TEST][TP_EN_BIT];
  assign tp_clk     = words[W_TEST][TP_CLK_BIT];
  assign tp_clr     = words[W_TEST][TP_CLR_BIT];
endmodule

// File: rtl/hwm_ctrl_bank_chk.sv
module hwm_ctrl_bank_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_valid,
  input logic        bus_write,
  input logic [31:0] bus_wdata,
  input logic        rd_req,
  input logic [2:0]  wr_hit,
  input logic        status_sel,
  input logic        addr_mapped,
  input logic        rd_valid,
  input logic [31:0] rd_data,
  input logic [3:0]  lane_en,
  input logic [3:0]  force_rx,
  input logic [3:0]  force_stop,
  input logic [3:0]  turn_dis,
  input logic [3:0]  turn_req,
  input logic [1:0]  clk_inv,
  input logic [7:0]  tp_din,
  input logic        tp_en,
  input logic        tp_clk,
  input logic        tp_clr,
  input logic [7:0]  tp_dout
);
  logic [36:0] all_ctrl;
  assign all_ctrl = {lane_en, force_rx, force_stop, turn_dis, turn_req,
                     clk_inv, tp_din, tp_en, tp_clk, tp_clr};

  // R8
  rdata_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> rd_data[31:16] == 16'h0);

  // R8
  rd_valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write) |=> rd_valid);

  // R8
  rd_valid_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rd_valid);

  // R8
  read_no_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && bus_write) |=> $stable(all_ctrl));

  // R2
  zero_enable_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && bus_wdata[31:16] == 16'h0) |=> $stable(all_ctrl));

  // R9
  unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && !addr_mapped) |=> $stable(all_ctrl));

  // R7
  status_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && status_sel) |=> $stable(all_ctrl));

  // R7
  status_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && status_sel) |=> rd_data == {24'h0, $past(tp_dout)});

  // R4
  lane_full_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit[0] && bus_wdata[19:16] == 4'hF) |=> lane_en == $past(bus_wdata[3:0]));

  // R6
  tp_clr_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit[2] && bus_wdata[26]) |=> tp_clr == $past(bus_wdata[10]));

  // R2
  tp_clr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_hit[2] && bus_wdata[26]) |=> $stable(tp_clr));
endmodule

bind hwm_ctrl_bank hwm_ctrl_bank_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_valid   (bus_valid),
  .bus_write   (bus_write),
  .bus_wdata   (bus_wdata),
  .rd_req      (rd_req),
  .wr_hit      (wr_hit),
  .status_sel  (status_sel),
  .addr_mapped (addr_mapped),
  .rd_valid    (rd_valid),
  .rd_data     (rd_data),
  .lane_en     (lane_en),
  .force_rx    (force_rx),
  .force_stop  (force_stop),
  .turn_dis    (turn_dis),
  .turn_req    (turn_req),
  .clk_inv     (clk_inv),
  .tp_din      (tp_din),
  .tp_en       (tp_en),
  .tp_clk      (tp_clk),
  .tp_clr      (tp_clr),
  .tp_dout     (tp_dout)
);

// File: tb/hwm_ctrl_bank_bench.sv
module hwm_ctrl_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic [3:0]  lane_en, force_rx, force_stop, turn_dis, turn_req;
  logic [1:0]  clk_inv;
  logic [7:0]  tp_din;
  logic        tp_en, tp_clk, tp_clr;
  logic [7:0]  tp_dout = '0;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [15:0] model [3];
  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #4 clk = ~clk;

  hwm_ctrl_bank u_hwm_ctrl_bank (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_valid(rd_valid),
    .rd_data(rd_data), .lane_en(lane_en), .force_rx(force_rx),
    .force_stop(force_stop), .turn_dis(turn_dis), .turn_req(turn_req),
    .clk_inv(clk_inv), .tp_din(tp_din), .tp_en(tp_en), .tp_clk(tp_clk),
    .tp_clr(tp_clr), .tp_dout(tp_dout)
  );

  // stored-bit masks restated from R4..R6
  function automatic logic [15:0] keep_bits(input int w);
    if (w == 0) return 16'hFFFF;
    if (w == 1) return 16'h0C0F;
    return 16'h07FF;
  endfunction

  task automatic compare(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic check_pins(input string req);
    logic [63:0] got, exp;
    got = {27'h0, lane_en, force_rx, force_stop, turn_dis, turn_req, clk_inv,
           tp_din, tp_en, tp_clk, tp_clr};
    exp = {27'h0, model[0][3:0], model[0][7:4], model[0][11:8], model[0][15:12],
           model[1][3:0], model[1][11:10], model[2][7:0], model[2][8],
           model[2][9], model[2][10]};
    compare(req, got, exp);
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [15:0] en,
                        input logic [15:0] d, input string req);
    int w;
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = {en, d};
    w = int'(a >> 2);
    if (w < 3) model[w] = ((model[w] & ~en) | (d & en)) & keep_bits(w);
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
    check_pins(req);
  endtask

  task automatic rd_issue(input logic [7:0] a, input string req);
    int w;
    logic [31:0] e;
    w = int'(a >> 2);
    if (w < 3)       e = {16'h0, model[w]};
    else if (w == 3) e = {24'h0, tp_dout};
    else             e = 32'h0;
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    exp_q.push_back(e);
    tag_q.push_back(req);
  endtask

  task automatic bus_idle();
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  // monitor: pops expected read items as responses appear
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R8 actual=unexpected rd_valid expected=none");
      end else begin
        compare(tag_q.pop_front(), {32'h0, rd_data}, {32'h0, exp_q.pop_front()});
      end
    end
  end

  initial begin : watchdog
    for (int i = 0; i < 20000; i++) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 3; k++) model[k] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check_pins("R1");
    compare("R1 rd_valid", {63'h0, rd_valid}, 64'h0);
    rst_n = 1'b1;
    rd_issue(8'h00, "R1 lane"); rd_issue(8'h04, "R1 aux"); rd_issue(8'h08, "R1 test");
    bus_idle(); bus_idle();

    // R4 R3 full lane write
    bus_wr(8'h00, 16'hFFFF, 16'h5A3C, "R4 R3 lane full");
    // R2 one field only, neighbours hold opposite pattern
    bus_wr(8'h00, 16'h00F0, 16'hFFFF, "R2 force_rx only");
    bus_wr(8'h00, 16'h0000, 16'h0000, "R2 zero enable");
    bus_wr(8'h00, 16'h8001, 16'h0000, "R2 scattered bits");
    rd_issue(8'h00, "R8 lane readback"); bus_idle(); bus_idle();

    // R5 aux word
    bus_wr(8'h04, 16'hFFFF, 16'hFFFF, "R5 aux all");
    rd_issue(8'h04, "R5 aux readback"); bus_idle(); bus_idle();
    bus_wr(8'h04, 16'h0400, 16'h0000, "R5 clk_inv0 clear");

    // R6 test port
    bus_wr(8'h08, 16'hFFFF, 16'hFFFF, "R6 test all");
    rd_issue(8'h08, "R6 test readback"); bus_idle(); bus_idle();
    bus_wr(8'h08, 16'h0200, 16'h0000, "R6 tp_clk only");
    bus_wr(8'h08, 16'h00FF, 16'h0096, "R6 tp_din");

    // R7 status
    tp_dout = 8'hA5;
    rd_issue(8'h0C, "R7 status"); bus_idle(); bus_idle();
    bus_wr(8'h0C, 16'hFFFF, 16'h0000, "R7 status write ignored");
    tp_dout = 8'h3C;
    rd_issue(8'h0C, "R7 status again"); bus_idle(); bus_idle();

    // R9 unmapped
    bus_wr(8'h10, 16'hFFFF, 16'h0000, "R9 write 0x10");
    bus_wr(8'hFC, 16'hFFFF, 16'h0000, "R9 write 0xFC");
    rd_issue(8'h10, "R9 read 0x10"); bus_idle(); bus_idle();

    // R10 low address bits ignored
    bus_wr(8'h05, 16'h000F, 16'h0009, "R10 addr 0x05");
    rd_issue(8'h07, "R10 read 0x07"); bus_idle(); bus_idle();

    // R8 back-to-back reads, then pins untouched
    rd_issue(8'h00, "R8 burst lane");
    rd_issue(8'h04, "R8 burst aux");
    rd_issue(8'h08, "R8 burst test");
    rd_issue(8'h0C, "R8 burst status");
    bus_idle(); bus_idle();
    check_pins("R8 read no side effect");
    compare("R8 rd_valid drops", {63'h0, rd_valid}, 64'h0);
    compare("R8 queue drained", 64'(exp_q.size()), 64'h0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule